// File: doc/BRIEF.md
# Interrupt controller error status register

This block holds the error status register of an interrupt controller and the error-interrupt trigger that goes with it. Error events arrive as bit masks on a one-cycle strobe. They are collected in a hidden pending accumulator and are not shown to software straight away. When software writes the status register, the block ignores the data. It copies the accumulated errors into the visible register, empties the accumulator and re-arms the trigger. Reads return the visible value.

A local-vector-table style error entry is also in this block. It holds an 8-bit vector and a mask bit. When the first error after a re-arm arrives and the entry is unmasked, the block raises a one-cycle interrupt request that carries the entry's vector. An extended-mode input makes the status register accept only zero writes. A rejected write is itself logged as an illegal-register-address error.

Top module: `esr_unit`

## Requirements
- R1: After reset, a read of the status register (offset 8) returns 0. A read of the error entry (offset 7) returns 0x0001_0000, which means masked with vector 0. `irq_valid` is low.
- R2: An accepted write to offset 8 ignores `wr_data`. From the next cycle the status register reads back every error logged since the previous accepted write.
- R3: An accepted write empties the accumulator. A second write with no errors in between makes the status register read 0.
- R4: Reads have no side effects. Repeated reads return the same value, and they do not change what the next write transfers.
- R5: An error mask is ORed into the hidden accumulator. The visible register changes only on an accepted status write.
- R6: `irq_valid` pulses for one cycle, one cycle after an error event, with `irq_vector` equal to bits 7:0 of the error entry. It pulses only when the accumulator was empty before the event. Further errors raise nothing until a status write re-arms the trigger.
- R7: While bit 16 of the error entry is set, no interrupt is raised, but errors still accumulate.
- R8: When `x2_mode` is high, a nonzero write to offset 8 is rejected. The visible register is kept, and bit 7 (illegal register address) is set in the accumulator, which counts as an error event. A zero write in this mode is accepted.
- R9: When an error event and an accepted write fall in the same cycle, the write transfers the old accumulator. The new error lands in the emptied accumulator as the first error after the re-arm, so it can raise the interrupt.
- R10: Status bits: 0 send checksum, 1 receive checksum, 2 send accept, 3 receive accept, 4 redirectable IPI, 5 send illegal vector, 6 receive illegal vector, 7 illegal register address. Bits 31:8 read 0. The error entry stores only bits 7:0 and bit 16. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_mode | input | 1 | Extended mode: only zero writes to the status register are accepted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset (8 status, 7 error entry) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| err_valid | input | 1 | Error event strobe |
| err_mask | input | 8 | Error bits of the event |
| irq_valid | output | 1 | Error interrupt request pulse |
| irq_vector | output | 8 | Vector of the request |

## Verification
Every register changes at the clock edge that closes the cycle in which its stimulus was driven. The visible value is therefore due one edge after the write. The interrupt pulse is due one edge after the error event or the rejected write, and it must be gone one edge after that. The bench drives inputs on the falling edge and returns after the next falling edge. It samples `irq_valid` there for the pulse and again one cycle later for its end. Reads are combinational, so each read is sampled a short delay after `rd_addr` is set, in a cycle with no write.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int ERR_W = 8;
  // status bit positions
  localparam int B_TX_CSUM   = 0;
  localparam int B_RX_CSUM   = 1;
  localparam int B_TX_ACCEPT = 2;
  localparam int B_RX_ACCEPT = 3;
  localparam int B_REDIR_IPI = 4;
  localparam int B_TX_BADVEC = 5;
  localparam int B_RX_BADVEC = 6;
  localparam int B_BAD_REG   = 7;
endpackage

// File: rtl/esr_accum.sv
module esr_accum #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] ev_mask,
  input  logic             xfer,
  output logic [ERR_W-1:0] pend_q,
  output logic [ERR_W-1:0] stat_q,
  output logic             first_err
);
  logic [ERR_W-1:0] base;
  logic [ERR_W-1:0] pend_d;
  logic             pend_en;

  always_comb begin
    base      = xfer ? '0 : pend_q;
    pend_d    = base | ev_mask;
    pend_en   = xfer || (ev_mask != '0);
    first_err = (base == '0) && (ev_mask != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (xfer)    stat_q <= pend_q;
    end
  end
endmodule

// File: rtl/esr_lvt.sv
module esr_lvt #(
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int MASK_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [VEC_W-1:0]  wr_vec,
  input  logic              wr_msk,
  output logic [VEC_W-1:0]  vec_q,
  output logic              msk_q,
  output logic [DATA_W-1:0] rd_word
);
  always_comb begin
    rd_word                = '0;
    rd_word[VEC_W-1:0]     = vec_q;
    rd_word[MASK_BIT]      = msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      msk_q <= 1'b1;
    end else if (wr) begin
      vec_q <= wr_vec;
      msk_q <= wr_msk;
    end
  end
endmodule

// File: rtl/esr_irq.sv
module esr_irq #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [VEC_W-1:0] vec_in,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= fire;
      if (fire) irq_vector <= vec_in;
    end
  end
endmodule

// File: rtl/esr_unit.sv
module esr_unit #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int VEC_W    = 8,
  parameter int MASK_BIT = 16,
  parameter int ESR_OFS  = 8,
  parameter int LVT_OFS  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      x2_mode,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      err_valid,
  input  logic [esr_pkg::ERR_W-1:0] err_mask,
  output logic                      irq_valid,
  output logic [VEC_W-1:0]          irq_vector
);
  localparam int ERR_W = esr_pkg::ERR_W;
  localparam logic [ADDR_W-1:0] ESR_A = ADDR_W'(ESR_OFS);
  localparam logic [ADDR_W-1:0] LVT_A = ADDR_W'(LVT_OFS);
  localparam logic [ERR_W-1:0] BAD_REG_BIT = ERR_W'(1) << esr_pkg::B_BAD_REG;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  logic             esr_wr, lvt_wr, reject, xfer, fire;
  logic [ERR_W-1:0] ev_mask, pend_q, stat_q;
  logic             first_err;
  logic [VEC_W-1:0] lvt_vec;
  logic             lvt_msk;
  logic [DATA_W-1:0] lvt_word;

  always_comb begin
    esr_wr  = wr_en && (wr_addr == ESR_A);
    lvt_wr  = wr_en && (wr_addr == LVT_A);
    reject  = esr_wr && x2_mode && (wr_data != '0);
    xfer    = esr_wr && !reject;
    ev_mask = (err_valid ? err_mask : '0) | (reject ? BAD_REG_BIT : '0);
    fire    = first_err && !lvt_msk;
  end

  esr_accum #(.ERR_W(ERR_W)) u_accum (
    .clk(clk), .rst_n(rst_q_n), .ev_mask(ev_mask), .xfer(xfer),
    .pend_q(pend_q), .stat_q(stat_q), .first_err(first_err)
  );

  esr_lvt #(.DATA_W(DATA_W), .VEC_W(VEC_W), .MASK_BIT(MASK_BIT)) u_lvt (
    .clk(clk), .rst_n(rst_q_n), .wr(lvt_wr),
    .wr_vec(wr_data[VEC_W-1:0]), .wr_msk(wr_data[MASK_BIT]),
    .vec_q(lvt_vec), .msk_q(lvt_msk), .rd_word(lvt_word)
  );

  esr_irq #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst_n(rst_q_n), .fire(fire), .vec_in(lvt_vec),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always_comb begin
    if (rd_addr == ESR_A)      rd_data = {{(DATA_W-ERR_W){1'b0}}, stat_q};
    else if (rd_addr == LVT_A) rd_data = lvt_word;
    else                       rd_data = '0;
  end
endmodule

// File: rtl/esr_unit_chk.sv
module esr_unit_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer,
  input logic             reject,
  input logic             err_valid,
  input logic [ERR_W-1:0] pend_q,
  input logic [ERR_W-1:0] stat_q,
  input logic             lvt_msk,
  input logic             irq_valid
);
  AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> stat_q == $past(pend_q)); // R2
  AST_VISIBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(stat_q)); // R5
  AST_REJECT_LOGS: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> pend_q[ERR_W-1] && $stable(stat_q)); // R8
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(lvt_msk)); // R7
  AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (($past(pend_q) == '0) || $past(xfer))); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(err_valid || reject)); // R6
endmodule

bind esr_unit esr_unit_chk #(.ERR_W(esr_pkg::ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .xfer(xfer), .reject(reject),
  .err_valid(err_valid), .pend_q(pend_q), .stat_q(stat_q),
  .lvt_msk(lvt_msk), .irq_valid(irq_valid)
);

// File: tb/esr_unit_bench.sv
module esr_unit_bench;
  localparam int CLK_P = 10;
  localparam logic [3:0] ESR = 4'd8;
  localparam logic [3:0] LVT = 4'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x2_mode = 1'b0, wr_en = 1'b0, err_valid = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] err_mask = '0;
  logic [31:0] rd_data;
  logic irq_valid;
  logic [7:0] irq_vector;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  esr_unit u_esr_unit (
    .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_valid(err_valid), .err_mask(err_mask),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  // one bus cycle: optional write and optional error event
  task automatic cyc(input bit we, input logic [3:0] a, input logic [31:0] d,
                     input bit ev, input logic [7:0] m);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; err_valid = ev; err_mask = m;
    @(negedge clk);
    wr_en = 1'b0; err_valid = 1'b0; err_mask = '0; wr_data = '0;
  endtask

  task automatic irq_chk(input bit exp_v, input logic [7:0] exp_vec, input string req);
    chk(irq_valid === exp_v, req, {31'd0, irq_valid}, {31'd0, exp_v});
    if (exp_v) chk(irq_vector === exp_vec, req, {24'd0, irq_vector}, {24'd0, exp_vec});
  endtask

  task automatic t_reset;
    rd_chk(ESR, 32'h0, "R1 status");
    rd_chk(LVT, 32'h0001_0000, "R1 entry");
    irq_chk(1'b0, 8'h0, "R1 irq");
  endtask

  task automatic t_collect;
    cyc(1, LVT, 32'h0000_0042, 0, 8'h0);
    cyc(0, 4'd0, 32'h0, 1, 8'h01);
    irq_chk(1'b1, 8'h42, "R6 first error");
    @(negedge clk);
    irq_chk(1'b0, 8'h0, "R6 single pulse");
    rd_chk(ESR, 32'h0, "R5 hidden");
    cyc(0, 4'd0, 32'h0, 1, 8'h04);
    irq_chk(1'b0, 8'h0, "R6 not rearmed");
    cyc(1, ESR, 32'hFFFF_FFFF, 0, 8'h0);
    rd_chk(ESR, 32'h05, "R2 transfer ignores data");
    cyc(0, 4'd0, 32'h0, 1, 8'h08);
    irq_chk(1'b1, 8'h42, "R6 rearmed by write");
    cyc(1, ESR, 32'h0, 0, 8'h0);
    cyc(1, ESR, 32'h0, 0, 8'h0);
    rd_chk(ESR, 32'h0, "R3 cleared");
  endtask

  task automatic t_read;
    cyc(0, 4'd0, 32'h0, 1, 8'h10);
    cyc(1, ESR, 32'h0, 0, 8'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rd_chk(ESR, 32'h10, "R4 repeat read");
    end
    cyc(0, 4'd0, 32'h0, 1, 8'h20);
    rd_chk(ESR, 32'h10, "R4 read");
    cyc(1, ESR, 32'h0, 0, 8'h0);
    rd_chk(ESR, 32'h20, "R4 write after reads");
  endtask

  task automatic t_masked;
    cyc(1, LVT, 32'h0001_0033, 0, 8'h0);
    cyc(1, ESR, 32'h0, 0, 8'h0);
    cyc(0, 4'd0, 32'h0, 1, 8'h02);
    irq_chk(1'b0, 8'h0, "R7 masked");
    cyc(1, ESR, 32'h0, 0, 8'h0);
    rd_chk(ESR, 32'h02, "R7 still logged");
  endtask

  task automatic t_x2;
    cyc(1, LVT, 32'h0000_0055, 0, 8'h0);
    x2_mode = 1'b1;
    cyc(1, ESR, 32'h1, 0, 8'h0);
    irq_chk(1'b1, 8'h55, "R8 reject is an error");
    rd_chk(ESR, 32'h02, "R8 visible kept");
    cyc(1, ESR, 32'h0, 0, 8'h0);
    rd_chk(ESR, 32'h80, "R8 bad-reg bit");
    x2_mode = 1'b0;
  endtask

  task automatic t_same;
    cyc(0, 4'd0, 32'h0, 1, 8'h20);
    irq_chk(1'b1, 8'h55, "R9 first");
    cyc(1, ESR, 32'h0, 1, 8'h40);
    irq_chk(1'b1, 8'h55, "R9 same-cycle error rearmed");
    rd_chk(ESR, 32'h20, "R9 old accumulator moved");
    cyc(1, ESR, 32'h0, 0, 8'h0);
    rd_chk(ESR, 32'h40, "R9 new error kept");
  endtask

  task automatic t_layout;
    cyc(1, LVT, 32'hFFFF_FFFF, 0, 8'h0);
    rd_chk(LVT, 32'h0001_00FF, "R10 entry fields");
    cyc(0, 4'd0, 32'h0, 1, 8'hFF);
    cyc(1, ESR, 32'h0, 0, 8'h0);
    rd_chk(ESR, 32'h0000_00FF, "R10 upper bits zero");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_collect();
        t_read();
        t_masked();
        t_x2();
        t_same();
        t_layout();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule